// File: doc/BRIEF.md
# Accumulator ALU with Signed Compare Flags

This block is the arithmetic stage of a one-address accumulator machine. It takes the accumulator operand R and an operand fetched from memory. From these it builds a small set of candidate results: pass the memory operand, add, subtract, increment, decrement, zero and pass R. A select-line multiplexer picks which candidate drives the result output. The result path is purely combinational, so it settles in the same cycle that the select and operand inputs change.

A separate compare strobe updates a three-bit condition register on the next clock edge. The register holds one flag each for greater, equal and less, from a signed comparison of the memory operand against R. The flags stay unchanged until the next strobe, so later conditional-jump logic can read them across any number of intervening operations.

Reset clears the register to all zeros, which marks that no compare has yet been done. All arithmetic wraps modulo 2^WIDTH and raises no overflow signal.

Top module: `acc_alu`

## Requirements
- R1: With `op_sel` = 0 the result equals `mem_opnd`, and with `op_sel` = 6 it equals `acc_opnd`; the result follows its inputs in the same cycle.
- R2: With `op_sel` = 1 the result is `acc_opnd + mem_opnd` modulo 2^16.
- R3: With `op_sel` = 2 the result is `acc_opnd - mem_opnd` modulo 2^16.
- R4: With `op_sel` = 3 the result is `mem_opnd + 1`, and with `op_sel` = 4 it is `mem_opnd - 1`, both modulo 2^16 (0xFFFF+1 gives 0, 0-1 gives 0xFFFF).
- R5: With `op_sel` = 5 or 7 the result is zero.
- R6: A clock edge with `cmp_en` high loads the flags from a two's-complement compare: `flag_gt` when `mem_opnd` > `acc_opnd`, `flag_eq` when equal, `flag_lt` when less (0x8000 is the most negative value and 0x7FFF the most positive).
- R7: After any compare exactly one of the three flags is 1.
- R8: On edges with `cmp_en` low the flags keep their value, whatever the operands and `op_sel` do.
- R9: While `rst_n` is low, and after its release until the first compare, all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the condition register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Select lines for the result multiplexer |
| acc_opnd | input | 16 | Accumulator operand R, two's complement |
| mem_opnd | input | 16 | Memory operand, two's complement |
| cmp_en | input | 1 | Compare strobe; loads the flags at the clock edge |
| result | output | 16 | Selected result |
| flag_gt | output | 1 | Memory operand was greater than R at the last compare |
| flag_eq | output | 1 | Operands were equal at the last compare |
| flag_lt | output | 1 | Memory operand was less than R at the last compare |

## Verification
A wrong select decode or a broken candidate shows on `result` in the same cycle as the operand change. The sweep pairs every select value with boundary operands, so a bad decode or a carry error is caught immediately. A fault in the compare, such as an unsigned compare or swapped operands, shows one edge after the strobe, and the sign-boundary pairs make such faults visible. A register that leaks updates without a strobe shows on the flags one edge after the operands move, and the bench checks for this after every compare.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_ADD   = 3'd1,
      OP_SUB   = 3'd2,
      OP_INC   = 3'd3,
      OP_DEC   = 3'd4,
      OP_ZERO  = 3'd5,
      OP_PASSR = 3'd6,
      OP_RSVD  = 3'd7
   } alu_op_e;

   localparam int OP_SEL_MIN = 3;

   localparam int CC_LT = 0;
   localparam int CC_EQ = 1;
   localparam int CC_GT = 2;
   localparam int CC_W  = 3;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int NCAND = 8
) (
   input  logic [WIDTH-1:0] r_in,
   input  logic [WIDTH-1:0] m_in,
   output logic [WIDTH-1:0] cand [NCAND]
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] sum_rm;
   logic [WIDTH-1:0] dif_rm;
   logic [WIDTH-1:0] m_plus;
   logic [WIDTH-1:0] m_minus;

   // Carry-chain adders; any carry out of the top bit is dropped (wrap).
   assign sum_rm  = r_in + m_in;
   assign dif_rm  = r_in + ~m_in + ONE;
   assign m_plus  = m_in + ONE;
   assign m_minus = m_in - ONE;

   generate
      for (genvar i = 0; i < NCAND; i++) begin : g_cand
         if (i == int'(OP_LOAD)) begin : g_load
            assign cand[i] = m_in;
         end else if (i == int'(OP_ADD)) begin : g_add
            assign cand[i] = sum_rm;
         end else if (i == int'(OP_SUB)) begin : g_sub
            assign cand[i] = dif_rm;
         end else if (i == int'(OP_INC)) begin : g_inc
            assign cand[i] = m_plus;
         end else if (i == int'(OP_DEC)) begin : g_dec
            assign cand[i] = m_minus;
         end else if (i == int'(OP_PASSR)) begin : g_passr
            assign cand[i] = r_in;
         end else begin : g_zero
            assign cand[i] = '0;
         end
      end
   endgenerate

   // R4
   always_comb begin
      if (m_in == '1) begin
         inc_wrap_chk: assert (m_plus == '0);
      end
   end

endmodule

// File: rtl/acc_alu_mux.sv
module acc_alu_mux #(
   parameter int WIDTH      = 16,
   parameter int SEL_W      = 3,
   parameter bit ONEHOT_MUX = 1'b1,
   localparam int NIN       = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [WIDTH-1:0] din [NIN],
   output logic [WIDTH-1:0] dout
);

   generate
      if (ONEHOT_MUX) begin : g_andor
         logic [NIN-1:0]   dec;
         logic [WIDTH-1:0] masked [NIN];

         always_comb begin
            dec = '0;
            dec[sel] = 1'b1;
         end

         for (genvar i = 0; i < NIN; i++) begin : g_mask
            assign masked[i] = din[i] & {WIDTH{dec[i]}};
         end

         always_comb begin
            dout = '0;
            for (int k = 0; k < NIN; k++) begin
               dout = dout | masked[k];
            end
         end
      end else begin : g_index
         assign dout = din[sel];
      end
   endgenerate

endmodule

// File: rtl/acc_alu_cmp.sv
module acc_alu_cmp
   import acc_alu_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit CMP_BY_SUB = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [WIDTH-1:0] r_in,
   input  logic [WIDTH-1:0] m_in,
   output logic [CC_W-1:0] cc
);

   logic m_lt_r;
   logic m_eq_r;
   logic [CC_W-1:0] cc_next;

   generate
      if (CMP_BY_SUB) begin : g_sub
         logic [WIDTH:0] diff;
         assign diff   = {m_in[WIDTH-1], m_in} - {r_in[WIDTH-1], r_in};
         assign m_lt_r = diff[WIDTH];
         assign m_eq_r = (diff == '0);
      end else begin : g_direct
         assign m_lt_r = $signed(m_in) < $signed(r_in);
         assign m_eq_r = (m_in == r_in);
      end
   endgenerate

   always_comb begin
      cc_next        = '0;
      cc_next[CC_LT] = m_lt_r;
      cc_next[CC_EQ] = m_eq_r;
      cc_next[CC_GT] = !m_lt_r && !m_eq_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc <= '0;
      end else if (en) begin
         cc <= cc_next;
      end
   end

   // R8
   cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cc));

   // R7
   cc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ($countones(cc) == 1));

   // R6
   cc_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ($signed(m_in) > $signed(r_in))) |=> cc[CC_GT]);

   // R6
   cc_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ($signed(m_in) < $signed(r_in))) |=> cc[CC_LT]);

   // R9
   cc_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cc));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter int SEL_W      = 3,
   parameter bit ONEHOT_MUX = 1'b1,
   parameter bit CMP_BY_SUB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] op_sel,
   input  logic [WIDTH-1:0] acc_opnd,
   input  logic [WIDTH-1:0] mem_opnd,
   input  logic             cmp_en,
   output logic [WIDTH-1:0] result,
   output logic             flag_gt,
   output logic             flag_eq,
   output logic             flag_lt
);

   localparam int NCAND = 1 << SEL_W;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("acc_alu: WIDTH must be at least 2");
      end
      if (SEL_W < OP_SEL_MIN) begin : g_bad_sel
         $error("acc_alu: SEL_W too small for the operation set");
      end
   endgenerate

   logic [WIDTH-1:0] cand [NCAND];
   logic [CC_W-1:0]  cc;

   acc_alu_arith #(
      .WIDTH (WIDTH),
      .NCAND (NCAND)
   ) arith_i (
      .r_in (acc_opnd),
      .m_in (mem_opnd),
      .cand (cand)
   );

   acc_alu_mux #(
      .WIDTH      (WIDTH),
      .SEL_W      (SEL_W),
      .ONEHOT_MUX (ONEHOT_MUX)
   ) mux_i (
      .sel  (op_sel),
      .din  (cand),
      .dout (result)
   );

   acc_alu_cmp #(
      .WIDTH      (WIDTH),
      .CMP_BY_SUB (CMP_BY_SUB)
   ) cmp_i (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (cmp_en),
      .r_in (acc_opnd),
      .m_in (mem_opnd),
      .cc   (cc)
   );

   assign flag_gt = cc[CC_GT];
   assign flag_eq = cc[CC_EQ];
   assign flag_lt = cc[CC_LT];

   // R5
   always_comb begin
      if (rst_n && (op_sel == SEL_W'(OP_ZERO))) begin
         zero_sel_chk: assert (result == '0);
      end
   end

   // R1
   always_comb begin
      if (rst_n && (op_sel == SEL_W'(OP_LOAD))) begin
         load_sel_chk: assert (result == mem_opnd);
      end
   end

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op_sel = 3'd0;
   logic [W-1:0]  acc_opnd = '0;
   logic [W-1:0]  mem_opnd = '0;
   logic          cmp_en = 1'b0;
   logic [W-1:0]  result;
   logic          flag_gt, flag_eq, flag_lt;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   acc_alu dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_sel   (op_sel),
      .acc_opnd (acc_opnd),
      .mem_opnd (mem_opnd),
      .cmp_en   (cmp_en),
      .result   (result),
      .flag_gt  (flag_gt),
      .flag_eq  (flag_eq),
      .flag_lt  (flag_lt)
   );

   logic [W-1:0] vals [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFE,
                               16'h7FFF, 16'h8000, 16'h8001, 16'hFFFE,
                               16'hFFFF, 16'h1234, 16'hC3A5, 16'h00FF};

   function automatic logic [W-1:0] exp_res(input int s, input logic [W-1:0] r,
                                             input logic [W-1:0] m);
      logic [W-1:0] one = 16'd1;
      case (s)
         0: return m;
         1: return r + m;
         2: return r - m;
         3: return m + one;
         4: return m - one;
         6: return r;
         default: return '0;
      endcase
   endfunction

   function automatic logic [2:0] exp_cc(input logic [W-1:0] r, input logic [W-1:0] m);
      int ri = int'($signed(r));
      int mi = int'($signed(m));
      if (mi > ri) return 3'b100;
      if (mi == ri) return 3'b010;
      return 3'b001;
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string res_tag(input int s);
      case (s)
         0: return "R1 load";
         6: return "R1 pass-r";
         1: return "R2 add";
         2: return "R3 sub";
         3: return "R4 inc";
         4: return "R4 dec";
         default: return "R5 zero";
      endcase
   endfunction

   initial begin
      logic [2:0] held;

      // R9: reset state
      #5;
      chk("R9 flags in reset", {13'd0, flag_gt, flag_eq, flag_lt}, '0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R9 flags after release", {13'd0, flag_gt, flag_eq, flag_lt}, '0);

      // R1..R5: every select against every operand pair
      for (int s = 0; s < 8; s++) begin
         for (int a = 0; a < 12; a++) begin
            for (int b = 0; b < 12; b++) begin
               op_sel   = 3'(s);
               acc_opnd = vals[a];
               mem_opnd = vals[b];
               #1;
               chk(res_tag(s), result, exp_res(s, vals[a], vals[b]));
            end
         end
      end

      // R6, R7, R8: compare each pair, then disturb inputs without strobe
      for (int a = 0; a < 12; a++) begin
         for (int b = 0; b < 12; b++) begin
            @(negedge clk);
            acc_opnd = vals[a];
            mem_opnd = vals[b];
            op_sel   = 3'(b % 8);
            cmp_en   = 1'b1;
            @(negedge clk);
            cmp_en = 1'b0;
            held = exp_cc(vals[a], vals[b]);
            chk("R6 compare flags", {13'd0, flag_gt, flag_eq, flag_lt}, {13'd0, held});
            chk("R7 one flag set", 16'($countones({flag_gt, flag_eq, flag_lt})), 16'd1);
            acc_opnd = vals[b];
            mem_opnd = vals[a] ^ 16'h8000;
            op_sel   = 3'd1;
            @(negedge clk);
            @(negedge clk);
            chk("R8 flags held", {13'd0, flag_gt, flag_eq, flag_lt}, {13'd0, held});
         end
      end

      // R9: reset again clears flags
      rst_n = 1'b0;
      #2;
      chk("R9 flags cleared by reset", {13'd0, flag_gt, flag_eq, flag_lt}, '0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule